// File: doc/BRIEF.md
# I2C Byte Transfer Engine

This block moves a single byte across an I2C bus on behalf of a controller that can act either as bus master or as an addressed slave. Software starts every byte by accessing the data register. A write starts a transmit and a read starts the next receive. The access counts only when the direction setting agrees with it and the engine is allowed to act, either because it is master or because a slave address match is present. An access that does not meet these conditions is dropped silently.

Bit timing comes from outside the block, as single-cycle strobes that mark SCL rising and SCL falling. The engine puts transmit data on SDA while SCL is low, most significant bit first, and samples receive data on each rising edge. In the ninth clock it samples the acknowledge, and when it is receiving it also drives the acknowledge itself. When the ninth clock ends it raises a one-cycle completion strobe. A START or STOP condition seen on the bus returns the bit counter to zero and cancels any byte that is in progress. The circuits that generate START and STOP, the SCL rate and arbitration sit in neighbouring blocks.

Top module: `i2c_byte_engine`

## Requirements
- R1: After reset, busy, byte_done, sda_pull and rx_ack are 0 and reg_rdata is 0x00.
- R2: A reg_wr while idle, with cfg_tx=1 and either cfg_master=1 or addr_match=1, starts a transmit. From the next cycle busy=1 and reg_rdata shows the written byte.
- R3: Transmit bits appear most significant bit first. Bit k (k=0 for the MSB) is held from the start of the byte, or from the k-th SCL falling strobe, until the next SCL falling strobe. During that interval sda_pull is the inverse of the bit (1 pulls SDA low).
- R4: A reg_rd while idle, with cfg_tx=0 and the engine enabled as in R2, starts a receive. sda_in is sampled on the first eight SCL rising strobes, MSB first. The assembled byte appears on reg_rdata together with byte_done and is held there until another transfer changes it.
- R5: A reg_rd with cfg_tx=1, or a reg_wr with cfg_tx=0, starts nothing: busy stays 0 and reg_rdata does not change.
- R6: With cfg_master=0 and addr_match=0, no access starts a transfer and reg_rdata does not change.
- R7: rx_ack takes the value of sda_in at the ninth SCL rising strobe of a byte (0 means acknowledged, 1 means not acknowledged) and keeps it until the next ninth clock.
- R8: In the ninth clock (from the eighth SCL falling strobe to the ninth), a receiving engine sets sda_pull=1 unless cfg_txnak=1. A transmitting engine releases SDA (sda_pull=0) in that clock.
- R9: The SCL falling strobe that ends the ninth clock makes byte_done 1 for exactly one cycle, starting the next cycle. busy goes to 0 in that same cycle.
- R10: Any reg_wr or reg_rd that arrives while busy=1 is ignored, including one in the same cycle as the falling strobe that ends the byte. The byte in flight is unchanged, and a write does not change reg_rdata.
- R11: bus_start or bus_stop cancels a byte in flight. From the next cycle busy=0 and sda_pull=0, no byte_done follows, and the next byte starts again from its MSB. An access in the same cycle as a bus condition is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_master | input | 1 | 1 when the controller is bus master |
| cfg_tx | input | 1 | Direction setting: 1 transmit, 0 receive |
| cfg_txnak | input | 1 | 1 makes a receiving engine leave the acknowledge high |
| addr_match | input | 1 | Slave address match held by the address logic |
| reg_wr | input | 1 | Data register write strobe |
| reg_wdata | input | DW | Data register write value |
| reg_rd | input | 1 | Data register read strobe |
| reg_rdata | output | DW | Data register contents |
| scl_rise | input | 1 | One-cycle strobe at each SCL rising edge |
| scl_fall | input | 1 | One-cycle strobe at each SCL falling edge |
| bus_start | input | 1 | START or repeated START detected |
| bus_stop | input | 1 | STOP detected |
| sda_in | input | 1 | Synchronised SDA level |
| sda_pull | output | 1 | 1 pulls SDA low (open drain) |
| busy | output | 1 | A byte is in flight |
| byte_done | output | 1 | One-cycle pulse when a byte completes |
| rx_ack | output | 1 | Acknowledge level sampled in the ninth clock |

## Verification
Two pairs of events can land on the same clock edge. One pair is the falling strobe that ends a byte and a new register access. The other is a bus START and a register access. For the first pair, the bench raises reg_wr in the same cycle as the final scl_fall. It then expects byte_done, busy low and an unchanged reg_rdata, with no new transfer started. For the second pair, the bench raises bus_start and reg_wr together in the middle of a byte. It expects the byte to be cancelled and the write dropped, and the next full byte must start again from its MSB.

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_master,
  input  logic          cfg_tx,
  input  logic          cfg_txnak,
  input  logic          addr_match,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          reg_rd,
  output logic [DW-1:0] reg_rdata,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          bus_start,
  input  logic          bus_stop,
  input  logic          sda_in,
  output logic          sda_pull,
  output logic          busy,
  output logic          byte_done,
  output logic          rx_ack
);
  localparam int CW = $clog2(DW + 2);
  localparam logic [CW-1:0] ACK_SLOT = CW'(DW);
  localparam logic [CW-1:0] LAST     = CW'(DW + 1);

  logic [DW-1:0] data_q, sh_q, sh_l;
  logic [CW-1:0] cnt_q;
  logic busy_q, tx_q, pull_q, done_q, ack_q;

  wire enabled = cfg_master | addr_match;
  wire bus_evt = bus_start | bus_stop;
  wire go_tx   = reg_wr &  cfg_tx & enabled & ~busy_q & ~bus_evt;
  wire go_rx   = reg_rd & ~cfg_tx & enabled & ~busy_q & ~bus_evt;

  assign sh_l = sh_q << cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      tx_q   <= 1'b0;
      pull_q <= 1'b0;
      done_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (bus_evt) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
        pull_q <= 1'b0;
      end else if (go_tx) begin
        busy_q <= 1'b1;
        tx_q   <= 1'b1;
        cnt_q  <= '0;
        sh_q   <= reg_wdata;
        data_q <= reg_wdata;
        pull_q <= ~reg_wdata[DW-1];
      end else if (go_rx) begin
        busy_q <= 1'b1;
        tx_q   <= 1'b0;
        cnt_q  <= '0;
        pull_q <= 1'b0;
      end else if (busy_q) begin
        if (scl_rise && cnt_q != LAST) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q < ACK_SLOT && !tx_q) sh_q <= {sh_q[DW-2:0], sda_in};
          if (cnt_q == ACK_SLOT) ack_q <= sda_in;
        end
        if (scl_fall) begin
          if (cnt_q == LAST) begin
            busy_q <= 1'b0;
            pull_q <= 1'b0;
            done_q <= 1'b1;
            if (!tx_q) data_q <= sh_q;
          end else if (cnt_q == ACK_SLOT) begin
            pull_q <= ~tx_q & ~cfg_txnak;
          end else begin
            pull_q <= tx_q & ~sh_l[DW-1];
          end
        end
      end
    end
  end

  assign reg_rdata = data_q;
  assign sda_pull  = pull_q;
  assign busy      = busy_q;
  assign byte_done = done_q;
  assign rx_ack    = ack_q;
endmodule

module i2c_byte_engine_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_master,
  input logic          addr_match,
  input logic          reg_wr,
  input logic          scl_fall,
  input logic          bus_start,
  input logic          bus_stop,
  input logic [DW-1:0] reg_rdata,
  input logic          sda_pull,
  input logic          busy,
  input logic          byte_done
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) byte_done |=> !byte_done); // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) byte_done |-> (!busy && $past(busy))); // R9
  AST_IDLE_RELEASES_SDA: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !sda_pull); // R11
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (busy && reg_wr && !scl_fall) |=> $stable(reg_rdata)); // R10
  AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !cfg_master && !addr_match) |=> !busy); // R6
  AST_BUS_EVENT_CANCELS: assert property (@(posedge clk) disable iff (!rst_n) (bus_start || bus_stop) |=> (!busy && !byte_done)); // R11
endmodule

bind i2c_byte_engine i2c_byte_engine_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .addr_match(addr_match),
  .reg_wr(reg_wr), .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop),
  .reg_rdata(reg_rdata), .sda_pull(sda_pull), .busy(busy), .byte_done(byte_done)
);

// File: tb/i2c_byte_engine_tb_top.sv
module i2c_byte_engine_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_master = 1'b1, cfg_tx = 1'b1, cfg_txnak = 1'b0, addr_match = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic scl_rise = 1'b0, scl_fall = 1'b0, bus_start = 1'b0, bus_stop = 1'b0;
  logic ext_sda = 1'b1;
  logic sda_in, sda_pull, busy, byte_done, rx_ack;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;
  assign sda_in = ext_sda & ~sda_pull;

  i2c_byte_engine #(.DW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_tx(cfg_tx),
    .cfg_txnak(cfg_txnak), .addr_match(addr_match), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .bus_start(bus_start),
    .bus_stop(bus_stop), .sda_in(sda_in), .sda_pull(sda_pull), .busy(busy),
    .byte_done(byte_done), .rx_ack(rx_ack)
  );

  function automatic logic exp_tx_pull(input logic [7:0] b, input int k);
    return ~b[7-k];
  endfunction

  function automatic logic exp_ack_pull(input logic txing, input logic nak);
    return !txing && !nak;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask
  task automatic rise(); scl_rise = 1'b1; tick(); scl_rise = 1'b0; endtask
  task automatic fall(); scl_fall = 1'b1; tick(); scl_fall = 1'b0; endtask

  task automatic wr(input logic [7:0] b);
    reg_wdata = b; reg_wr = 1'b1; tick(); reg_wr = 1'b0;
  endtask
  task automatic rd(); reg_rd = 1'b1; tick(); reg_rd = 1'b0; endtask

  task automatic do_tx(input logic [7:0] b, input logic a, input bit inject, input bit late_wr);
    cfg_tx = 1'b1;
    wr(b);
    chk("R2 busy after write", busy, 1);
    chk("R2 data register", reg_rdata, b);
    for (int k = 0; k < 8; k++) begin
      ext_sda = 1'b1;
      chk("R3 tx bit", sda_pull, exp_tx_pull(b, k));
      tick(); rise(); tick();
      if (inject && k == 3) begin
        wr(~b);
        chk("R10 busy kept", busy, 1);
        chk("R10 data kept", reg_rdata, b);
      end
      fall(); tick();
    end
    chk("R8 tx releases ack", sda_pull, exp_ack_pull(1'b1, cfg_txnak));
    ext_sda = a;
    rise();
    ext_sda = 1'b1;
    tick();
    if (late_wr) begin
      reg_wdata = 8'h3C; reg_wr = 1'b1; scl_fall = 1'b1;
      tick();
      reg_wr = 1'b0; scl_fall = 1'b0;
      chk("R10 late write ignored busy", busy, 0);
      chk("R10 late write ignored data", reg_rdata, b);
    end else begin
      fall();
    end
    chk("R9 done pulse", byte_done, 1);
    chk("R9 busy cleared", busy, 0);
    chk("R7 ack sampled", rx_ack, a);
    tick();
    chk("R9 done one cycle", byte_done, 0);
  endtask

  task automatic do_rx(input logic [7:0] r, input logic n);
    cfg_tx = 1'b0; cfg_txnak = n;
    rd();
    chk("R4 busy after read", busy, 1);
    for (int k = 0; k < 8; k++) begin
      ext_sda = r[7-k];
      chk("R4 rx sda released", sda_pull, 0);
      tick(); rise(); ext_sda = 1'b1; tick(); fall();
    end
    chk("R8 rx ack drive", sda_pull, exp_ack_pull(1'b0, n));
    rise(); tick(); fall();
    chk("R9 rx done pulse", byte_done, 1);
    chk("R4 received byte", reg_rdata, r);
    chk("R7 own ack level", rx_ack, n);
    tick();
    chk("R9 rx done one cycle", byte_done, 0);
    chk("R4 byte held", reg_rdata, r);
    cfg_txnak = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] b, prev;
    void'($urandom(32'h0001_2C5A));
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk("R1 busy", busy, 0);
    chk("R1 done", byte_done, 0);
    chk("R1 pull", sda_pull, 0);
    chk("R1 ack", rx_ack, 0);
    chk("R1 data", reg_rdata, 8'h00);

    do_tx(8'hA5, 1'b0, 1'b0, 1'b0);
    do_tx(8'h00, 1'b1, 1'b0, 1'b0);
    do_rx(8'hFF, 1'b0);
    do_rx(8'h5A, 1'b1);

    cfg_tx = 1'b1; prev = reg_rdata;
    rd(); tick();
    chk("R5 read in tx mode", busy, 0);
    cfg_tx = 1'b0;
    wr(8'h77); tick();
    chk("R5 write in rx mode busy", busy, 0);
    chk("R5 write in rx mode data", reg_rdata, prev);

    cfg_master = 1'b0; addr_match = 1'b0; cfg_tx = 1'b1;
    wr(8'h42); tick();
    chk("R6 disabled write busy", busy, 0);
    chk("R6 disabled write data", reg_rdata, prev);
    cfg_tx = 1'b0;
    rd(); tick();
    chk("R6 disabled read busy", busy, 0);
    addr_match = 1'b1;
    do_tx(8'hC3, 1'b0, 1'b0, 1'b0);

    cfg_master = 1'b1; addr_match = 1'b0;
    do_tx(8'h96, 1'b0, 1'b1, 1'b0);
    do_tx(8'h69, 1'b1, 1'b0, 1'b1);

    cfg_tx = 1'b1;
    wr(8'hE1);
    for (int k = 0; k < 3; k++) begin tick(); rise(); tick(); fall(); end
    reg_wdata = 8'h11; reg_wr = 1'b1; bus_start = 1'b1;
    tick();
    reg_wr = 1'b0; bus_start = 1'b0;
    chk("R11 cancel busy", busy, 0);
    chk("R11 cancel pull", sda_pull, 0);
    chk("R11 no done", byte_done, 0);
    chk("R11 same-cycle write ignored", reg_rdata, 8'hE1);
    tick();
    chk("R11 no late done", byte_done, 0);
    do_tx(8'h3B, 1'b0, 1'b0, 1'b0);
    cfg_tx = 1'b1;
    wr(8'h80);
    tick(); rise(); tick(); fall();
    bus_stop = 1'b1; tick(); bus_stop = 1'b0;
    chk("R11 stop cancels", busy, 0);
    do_tx(8'h7E, 1'b1, 1'b0, 1'b0);

    for (int i = 0; i < 40; i++) begin
      b = 8'($urandom);
      if ($urandom % 2 == 0) begin
        cfg_master = 1'b1; addr_match = 1'b0;
      end else begin
        cfg_master = 1'b0; addr_match = 1'b1;
      end
      if ($urandom % 2 == 0) do_tx(b, 1'($urandom), 1'b0, 1'b0);
      else do_rx(b, 1'($urandom));
      tick();
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule